// File: doc/BRIEF.md
# FDDI Line State Recognizer

This block sits behind an FDDI physical receiver's symbol decoder and classifies the incoming line. Each cycle in which `pair_vld` is high it takes one pair of 5-bit code groups. It decides whether the line is in Idle, Super Idle, Active or Unknown line state.

Classification counts consecutive idle pairs, with one threshold for Idle and a higher one for Super Idle. A J-K start delimiter moves the line to Active, and Active holds while data pairs follow. Unknown is reached only by leaving a known state: an unexpected pair arrives while the line is Idle, Super Idle or Active. Each entry into a new state raises a one-cycle pulse on the matching output, ready to set a sticky bit in a status register.

Top module: `line_state_detect`

## Requirements
- R1: After reset, `line_st` is 2'b00 (Unknown), `line_idle` is low and no entry pulse is high.
- R2: An idle pair is the code group 11111 in both `sym_a` and `sym_b`. The pair that completes a run of `IDLE_RUN` (default 2) consecutive idle pairs moves `line_st` to 2'b01 (Idle). `ent_idle` is high for the cycle after that pair's clock edge.
- R3: The pair that completes a run of `SUPER_RUN` (default 8) consecutive idle pairs moves `line_st` to 2'b10 (Super Idle) and pulses `ent_super`. `line_idle` is high in both Idle and Super Idle. Further idle pairs keep Super Idle without a new pulse, because the run counter saturates.
- R4: A pair with `sym_a` = 11000 (J) and `sym_b` = 10001 (K) moves `line_st` to 2'b11 (Active) from any other state, pulses `ent_active` and clears the idle run.
- R5: In Active, a pair of two data code groups keeps Active. The data code groups are 01001, 01010, 01011, 01110, 01111, 10010, 10011, 10100, 10101, 10110, 10111, 11010, 11011, 11100, 11101 and 11110. An idle run shorter than `IDLE_RUN` also keeps Active. The pair that completes `IDLE_RUN` idle pairs moves it to Idle.
- R6: Any valid pair that is not an idle pair clears the idle run. Idle, data, idle from Unknown therefore does not reach Idle.
- R7: In Idle or Super Idle, any pair that is neither idle nor J-K moves the state to Unknown. In Active, any pair that is neither data, idle nor J-K does the same. Each of these entries pulses `ent_unknown`. Such pairs received while already in Unknown leave it there with no pulse.
- R8: While `pair_vld` is low, the state and the idle run hold and no entry pulse is raised. An idle pair, a gap, then an idle pair reaches Idle.
- R9: Every entry pulse lasts a single cycle, and at most one of the four entry pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_vld | input | 1 | A code-group pair is present this cycle |
| sym_a | input | 5 | First code group of the pair |
| sym_b | input | 5 | Second code group of the pair |
| line_st | output | 2 | 00 Unknown, 01 Idle, 10 Super Idle, 11 Active |
| line_idle | output | 1 | Line is in Idle or Super Idle |
| ent_idle | output | 1 | One-cycle pulse on entry to Idle |
| ent_super | output | 1 | One-cycle pulse on entry to Super Idle |
| ent_active | output | 1 | One-cycle pulse on entry to Active |
| ent_unknown | output | 1 | One-cycle pulse on entry to Unknown |

## Verification
A wrong idle-run count appears as an Idle or Super Idle entry one or more pairs early or late. This shows on `line_st` and the entry pulse at the edge that accepts the threshold pair. A corrupted state register shows on `line_st` in the very next cycle. It also shifts every later entry pulse, since pulses are issued only on a change of state. The bench drives every pair against a behavioural model and compares all outputs each cycle, so any such fault surfaces within one pair of its cause.

// File: rtl/line_state_detect.sv
module line_state_detect #(
  parameter int IDLE_RUN  = 2,
  parameter int SUPER_RUN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pair_vld,
  input  logic [4:0] sym_a,
  input  logic [4:0] sym_b,
  output logic [1:0] line_st,
  output logic       line_idle,
  output logic       ent_idle,
  output logic       ent_super,
  output logic       ent_active,
  output logic       ent_unknown
);
  localparam int CW = $clog2(SUPER_RUN + 1);
  localparam logic [CW-1:0] IDLE_C  = CW'(IDLE_RUN);
  localparam logic [CW-1:0] SUPER_C = CW'(SUPER_RUN);

  localparam logic [1:0] ST_UNK = 2'b00;
  localparam logic [1:0] ST_IDL = 2'b01;
  localparam logic [1:0] ST_SUP = 2'b10;
  localparam logic [1:0] ST_ACT = 2'b11;

  function automatic logic is_data(input logic [4:0] s);
    case (s)
      5'b11110, 5'b01001, 5'b10100, 5'b10101,
      5'b01010, 5'b01011, 5'b01110, 5'b01111,
      5'b10010, 5'b10011, 5'b10110, 5'b10111,
      5'b11010, 5'b11011, 5'b11100, 5'b11101: is_data = 1'b1;
      default:                                is_data = 1'b0;
    endcase
  endfunction

  logic [1:0]    st_q, st_d;
  logic [CW-1:0] run_q, run_d, run_inc;

  wire idle_pr = (sym_a == 5'b11111) && (sym_b == 5'b11111);
  wire jk_pr   = (sym_a == 5'b11000) && (sym_b == 5'b10001);
  wire data_pr = is_data(sym_a) && is_data(sym_b);

  assign run_inc = (run_q >= SUPER_C) ? SUPER_C : run_q + 1'b1;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    if (pair_vld) begin
      run_d = idle_pr ? run_inc : '0;
      if (jk_pr)
        st_d = ST_ACT;
      else if (idle_pr) begin
        if (run_inc >= SUPER_C)     st_d = ST_SUP;
        else if (run_inc >= IDLE_C) st_d = ST_IDL;
      end else if (!(st_q == ST_ACT && data_pr))
        st_d = ST_UNK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_UNK;
      run_q       <= '0;
      ent_idle    <= 1'b0;
      ent_super   <= 1'b0;
      ent_active  <= 1'b0;
      ent_unknown <= 1'b0;
    end else begin
      st_q        <= st_d;
      run_q       <= run_d;
      ent_idle    <= (st_d != st_q) && (st_d == ST_IDL);
      ent_super   <= (st_d != st_q) && (st_d == ST_SUP);
      ent_active  <= (st_d != st_q) && (st_d == ST_ACT);
      ent_unknown <= (st_d != st_q) && (st_d == ST_UNK);
    end
  end

  assign line_st   = st_q;
  assign line_idle = (st_q == ST_IDL) || (st_q == ST_SUP);
endmodule

// File: rtl/line_state_detect_chk.sv
module line_state_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pair_vld,
  input logic [4:0] sym_a,
  input logic [4:0] sym_b,
  input logic [1:0] line_st,
  input logic       line_idle,
  input logic       ent_idle,
  input logic       ent_super,
  input logic       ent_active,
  input logic       ent_unknown
);
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ent_idle, ent_super, ent_active, ent_unknown}));

  a_r8_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_vld |=> $stable(line_st) && !ent_idle && !ent_super && !ent_active && !ent_unknown);

  a_r4_jk_active: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld && sym_a == 5'b11000 && sym_b == 5'b10001 |=> line_st == 2'b11);

  a_r3_super_via_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ent_super |-> line_st == 2'b10 && $past(line_st) == 2'b01);

  a_r7_unknown_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ent_unknown |-> line_st == 2'b00 && $past(line_st) != 2'b00);

  a_r2_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ent_idle |-> line_idle && line_st == 2'b01);
endmodule

bind line_state_detect line_state_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pair_vld(pair_vld), .sym_a(sym_a), .sym_b(sym_b),
  .line_st(line_st), .line_idle(line_idle), .ent_idle(ent_idle),
  .ent_super(ent_super), .ent_active(ent_active), .ent_unknown(ent_unknown)
);

// File: tb/sim_line_state_detect.sv
module sim_line_state_detect;
  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [4:0] sa = 5'd0, sb = 5'd0;
  logic [1:0] st;
  logic lid, e_i, e_s, e_a, e_u;
  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  line_state_detect u0 (
    .clk(clk), .rst_n(rst_n), .pair_vld(vld), .sym_a(sa), .sym_b(sb),
    .line_st(st), .line_idle(lid), .ent_idle(e_i), .ent_super(e_s),
    .ent_active(e_a), .ent_unknown(e_u));

  int m_st = 0, m_run = 0;
  int m_pulse = -1;

  function automatic bit dat(input logic [4:0] s);
    int list[16] = '{30, 9, 20, 21, 10, 11, 14, 15, 18, 19, 22, 23, 26, 27, 28, 29};
    foreach (list[k]) if (int'(s) == list[k]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    int nx;
    m_pulse = -1;
    if (!rst_n) begin
      m_st = 0; m_run = 0;
    end else if (vld) begin
      nx = m_st;
      if (sa == 5'd31 && sb == 5'd31) begin
        m_run = (m_run < 8) ? m_run + 1 : 8;
        if (m_run == 8) nx = 2;
        else if (m_run >= 2) nx = 1;
      end else begin
        m_run = 0;
        if (sa == 5'b11000 && sb == 5'b10001) nx = 3;
        else if (m_st == 3 && dat(sa) && dat(sb)) nx = 3;
        else nx = 0;
      end
      if (nx != m_st) m_pulse = nx;
      m_st = nx;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("line_st", st, m_st);
    chk("line_idle", lid, (m_st == 1 || m_st == 2));
    chk("ent_idle", e_i, m_pulse == 1);
    chk("ent_super", e_s, m_pulse == 2);
    chk("ent_active", e_a, m_pulse == 3);
    chk("ent_unknown", e_u, m_pulse == 0);
    req = "R9"; chk("pulse count", e_i + e_s + e_a + e_u, (m_pulse >= 0));
  end

  string cur = "R1";
  always @(negedge clk) req = cur;

  task automatic put(input logic [4:0] a, input logic [4:0] b, input bit v = 1);
    @(negedge clk); #1; sa = a; sb = b; vld = v;
  endtask
  task automatic idl(input int n); repeat (n) put(5'd31, 5'd31); endtask
  task automatic jk(); put(5'b11000, 5'b10001); endtask
  task automatic dp(); put(5'b10100, 5'b01110); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur = "R1"; req = "R1";
    chk("reset line_st", st, 0);
    chk("reset line_idle", lid, 0);
    chk("reset pulses", {e_i, e_s, e_a, e_u}, 0);
    rst_n = 1'b1;
    cur = "R6"; idl(1); dp(); idl(1); dp();
    cur = "R8"; idl(1); put(5'd31, 5'd31, 0); put(5'd0, 5'd0, 0); idl(1);
    cur = "R3"; idl(8);
    cur = "R7"; dp(); put(5'd0, 5'd0);
    cur = "R4"; jk();
    cur = "R5"; dp(); dp(); idl(1); dp(); idl(2); jk(); idl(1); jk();
    cur = "R7"; put(5'b00100, 5'b11111); put(5'b00111, 5'b00111);
    cur = "R2"; idl(2); idl(1);
    cur = "R4"; jk(); jk();
    cur = "R3"; idl(10);
    cur = "R4"; jk();
    cur = "R7"; put(5'b00000, 5'b00000);
    cur = "R8"; put(5'b11000, 5'b10001, 0); put(5'd31, 5'd31, 0);
    cur = "R2"; idl(3); put(5'd0, 5'd0, 0);
    repeat (3) @(negedge clk);
    #2 done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule